// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the integer arithmetic and logic stage of a three-operand load/store core. Each cycle it receives a first operand, a second operand that comes either from a register or from a 13-bit signed immediate, an operation code and a flag-write request. It returns a 32-bit result in the same cycle. It supports addition, subtraction, six bitwise functions and three shifts.

Beside the result it holds a 4-bit condition register with negative, zero, overflow and carry bits. This register is rewritten at the next clock edge only when the flag-write request accompanies an add, a subtract or a bitwise function. A compare is issued as a subtract with the flag-write request set, and the caller drops the result. Multiply, divide, floating point and register-file access are handled elsewhere.

Top module: `int_alu_cc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `flags` becomes 4'b0000 after that edge.
- R2: Op code 0 (add) returns `a + b2` modulo 2^32, and op code 1 (subtract) returns `a - b2` modulo 2^32, in the same cycle. Here `b2` is the selected second operand.
- R3: When `use_imm` is 1, `b2` is `imm13` sign-extended from bit 12 to 32 bits (range -4096 to 4095), and `b_reg` is ignored. When `use_imm` is 0, `b2` is `b_reg`.
- R4: The bitwise op codes apply to all 32 bits: 2 = a & b2, 3 = a | b2, 4 = a ^ b2, 5 = a & ~b2, 6 = a | ~b2, 7 = ~(a ^ b2).
- R5: Op code 8 shifts left and op code 9 shifts right, both filling with zeros. The shift count is `b2[4:0]`, and the upper bits of `b2` are ignored.
- R6: Op code 10 shifts right while copying bit 31 into the vacated bits, so a negative value is divided by 2^N rounding toward minus infinity.
- R7: With `set_cc` at 1 and op codes 0 to 7, `flags` is loaded at the next rising edge. The bit order is {N,Z,V,C}: bit 3 = result bit 31, bit 2 = result is zero.
- R8: For add, flag bit 1 marks signed overflow (operands of equal sign giving a result of the other sign), and bit 0 is the carry out of bit 31.
- R9: For subtract (and compare), flag bit 1 marks signed overflow, and bit 0 is a borrow: 1 exactly when `a` is unsigned-less-than `b2`.
- R10: For the bitwise op codes 2 to 7, a flag write clears bits 1 and 0.
- R11: `flags` keeps its value when `set_cc` is 0, and also for the shift op codes 8 to 10 even when `set_cc` is 1.
- R12: The unused op codes 11 to 15 return a result of 0 and never write `flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 4 | Operation code (see R2 to R6, R12) |
| a | input | 32 | First operand |
| b_reg | input | 32 | Second operand from a register |
| imm13 | input | 13 | Signed immediate second operand |
| use_imm | input | 1 | 1 selects the immediate as second operand |
| set_cc | input | 1 | Request to write the condition flags |
| result | output | 32 | Operation result, combinational |
| flags | output | 4 | Condition register {N,Z,V,C} |

## Verification
The result is purely combinational. It is due in the same cycle as its operands, so the bench drives inputs on a falling edge and samples `result` one time unit later, before any rising edge. The flags pass through one register. They are therefore sampled at the falling edge after the rising edge that follows the stimulus. Checks that flags were left untouched compare against the value seen just before that edge. Reset is checked at the falling edge after a reset-low rising edge.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and flag bit positions for the integer unit.
// Assumes a 4-bit op code; codes above OP_SRA are unused.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ANDN = 4'd5,
        OP_ORN  = 4'd6,
        OP_XNOR = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10
    } alu_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    // True for ops whose flag request is honoured.
    function automatic logic op_writes_flags(input logic [3:0] op);
        return op <= OP_XNOR;
    endfunction

    // True for the bitwise group.
    function automatic logic op_is_logic(input logic [3:0] op);
        return (op >= OP_AND) && (op <= OP_XNOR);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
// Module: picks the second operand, sign-extending the immediate when selected.
// Assumes IMM_W <= WIDTH.
module alu_operand_sel #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 13
) (
    input  logic [WIDTH-1:0] b_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic [WIDTH-1:0] b_out
);
    localparam int EXT_W = WIDTH - IMM_W;

    logic [WIDTH-1:0] imm_ext;

    // Replicate the immediate sign bit into the upper bits.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end

    // Choose register or immediate operand.
    always_comb begin
        b_out = use_imm ? imm_ext : b_reg;
    end
endmodule

// File: rtl/alu_addsub.sv
// Module: shared adder for add and subtract with carry/borrow and overflow.
// Assumes two's complement operands; subtract is a + ~b + 1.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_flag,
    output logic             ovf
);
    logic [WIDTH-1:0] b_eff;
    logic             cout;

    // Invert the second operand and inject a carry for subtract.
    always_comb begin
        b_eff        = do_sub ? ~b : b;
        {cout, sum}  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
    end

    // Derive carry (add) or borrow (subtract) and signed overflow.
    always_comb begin
        carry_flag = do_sub ? ~cout : cout;
        ovf        = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
    end
endmodule

// File: rtl/alu_logic.sv
// Module: six bitwise functions, including the complemented-operand forms.
// Assumes op is within the bitwise group; other codes give zero.
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] y
);
    import alu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
// Module: logical left/right and arithmetic right shift.
// Assumes WIDTH is a power of two; the count is the low log2(WIDTH) bits of b.
module alu_shift #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       op,
    output logic [WIDTH-1:0] y
);
    import alu_pkg::*;

    localparam int CNT_W = $clog2(WIDTH);

    logic [CNT_W-1:0] cnt;

    // Extract the shift count, ignoring upper bits.
    always_comb begin
        cnt = b[CNT_W-1:0];
    end

    // Perform the selected shift.
    always_comb begin
        case (op)
            OP_SLL:  y = a << cnt;
            OP_SRL:  y = a >> cnt;
            OP_SRA:  y = $unsigned($signed(a) >>> cnt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
// Module: 4-bit condition register with write enable.
// Assumes synchronous active-low reset clearing all bits.
module alu_flag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] nxt,
    output logic [3:0] q
);
    // Hold or load the flags at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= 4'b0000;
        else if (wr_en) q <= nxt;
    end
endmodule

// File: rtl/int_alu_cc.sv
// Module: integer execution unit returning a combinational result and
// keeping an optionally updated {N,Z,V,C} condition register.
// Assumes op codes from alu_pkg; unused codes yield zero and no flag write.
module int_alu_cc #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_sel,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b_reg,
    input  logic [IMM_W-1:0] imm13,
    input  logic             use_imm,
    input  logic             set_cc,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags
);
    import alu_pkg::*;

    logic [WIDTH-1:0] b2;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;
    logic             arith_c;
    logic             arith_v;
    logic [3:0]       flags_nxt;
    logic             flags_we;

    alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .b_reg   (b_reg),
        .imm     (imm13),
        .use_imm (use_imm),
        .b_out   (b2)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a          (a),
        .b          (b2),
        .do_sub     (op_sel == OP_SUB),
        .sum        (arith_y),
        .carry_flag (arith_c),
        .ovf        (arith_v)
    );

    alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (a),
        .b  (b2),
        .op (op_sel),
        .y  (logic_y)
    );

    alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a  (a),
        .b  (b2),
        .op (op_sel),
        .y  (shift_y)
    );

    // Steer the unit output onto the result port.
    always_comb begin
        if (op_sel <= OP_SUB)           result = arith_y;
        else if (op_is_logic(op_sel))   result = logic_y;
        else if (op_sel <= OP_SRA)      result = shift_y;
        else                            result = '0;
    end

    // Build the next flag value and its write enable.
    always_comb begin
        flags_nxt        = 4'b0000;
        flags_nxt[FLG_N] = result[WIDTH-1];
        flags_nxt[FLG_Z] = (result == '0);
        flags_nxt[FLG_V] = op_is_logic(op_sel) ? 1'b0 : arith_v;
        flags_nxt[FLG_C] = op_is_logic(op_sel) ? 1'b0 : arith_c;
        flags_we         = set_cc && op_writes_flags(op_sel);
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (flags_we),
        .nxt   (flags_nxt),
        .q     (flags)
    );
endmodule

// File: rtl/alu_cc_checker.sv
// Module: temporal checks on the integer unit's ports, bound to int_alu_cc.
// Assumes the op code values of alu_pkg.
module alu_cc_checker #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_sel,
    input logic [WIDTH-1:0] a,
    input logic [IMM_W-1:0] imm13,
    input logic             use_imm,
    input logic             set_cc,
    input logic [WIDTH-1:0] result,
    input logic [3:0]       flags
);
    // Reset clears the flags.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> flags == 4'b0000);

    // Immediate OR with zero exposes the sign-extended immediate.
    p_imm_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (use_imm && op_sel == 4'd3 && a == '0) |->
        result == {{(WIDTH-IMM_W){imm13[IMM_W-1]}}, imm13});

    // A flag write records the sign and zero of the result.
    p_nz_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && op_sel <= 4'd7) |=>
        (flags[3] == $past(result[WIDTH-1])) && (flags[2] == ($past(result) == '0)));

    // Bitwise flag writes clear overflow and carry.
    p_logic_clears_vc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_cc && op_sel >= 4'd2 && op_sel <= 4'd7) |=> flags[1:0] == 2'b00);

    // No request or a shift leaves the flags alone.
    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_cc || (op_sel >= 4'd8 && op_sel <= 4'd10)) |=> $stable(flags));

    // Unused codes give zero and keep the flags.
    p_unused_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd10) |-> result == '0);
    p_unused_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd10) |=> $stable(flags));
endmodule

bind int_alu_cc alu_cc_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .a       (a),
    .imm13   (imm13),
    .use_imm (use_imm),
    .set_cc  (set_cc),
    .result  (result),
    .flags   (flags)
);

// File: tb/tb_int_alu_cc.sv
module tb_int_alu_cc;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op_sel;
    logic [31:0] a;
    logic [31:0] b_reg;
    logic [12:0] imm13;
    logic        use_imm;
    logic        set_cc;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int_alu_cc dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .a(a), .b_reg(b_reg),
        .imm13(imm13), .use_imm(use_imm), .set_cc(set_cc),
        .result(result), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, check the combinational result, then the flags after one edge.
    task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] av,
                          input logic [31:0] bv, input logic [12:0] iv, input logic ui,
                          input logic cc, input logic [31:0] exp_res, input logic [3:0] exp_flg);
        @(negedge clk);
        op_sel = op; a = av; b_reg = bv; imm13 = iv; use_imm = ui; set_cc = cc;
        #1;
        check(req, result, exp_res);
        @(posedge clk);
        @(negedge clk);
        check(req, {28'd0, flags}, {28'd0, exp_flg});
        set_cc = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0; set_cc = 1'b0; op_sel = 4'd0;
        @(posedge clk); @(negedge clk);
        check("R1 reset", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add();
        run_op("R2 R8 add ovf", 4'd0, 32'h7FFF_FFFF, 32'd1, 13'd0, 1'b0, 1'b1, 32'h8000_0000, 4'b1010);
        run_op("R2 R8 add carry", 4'd0, 32'hFFFF_FFFF, 32'd1, 13'd0, 1'b0, 1'b1, 32'h0, 4'b0101);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] x = 32'h1234_5678 * (i + 1);
            logic [31:0] y = 32'h0F0F_1111 * (i + 3);
            run_op("R2 add loop", 4'd0, x, y, 13'd0, 1'b0, 1'b0, x + y, 4'b0101);
        end
    endtask

    task automatic t_sub();
        run_op("R9 sub borrow", 4'd1, 32'd5, 32'd7, 13'd0, 1'b0, 1'b1, 32'hFFFF_FFFE, 4'b1001);
        run_op("R9 sub ovf", 4'd1, 32'h8000_0000, 32'd1, 13'd0, 1'b0, 1'b1, 32'h7FFF_FFFF, 4'b0010);
        run_op("R9 compare equal", 4'd1, 32'd73, 32'hDEAD_BEEF, 13'd73, 1'b1, 1'b1, 32'd0, 4'b0100);
    endtask

    task automatic t_imm();
        run_op("R3 imm neg", 4'd0, 32'd10, 32'h5555_5555, 13'h1FF9, 1'b1, 1'b1, 32'd3, 4'b0001);
        run_op("R3 imm min", 4'd3, 32'd0, 32'd0, 13'h1000, 1'b1, 1'b0, 32'hFFFF_F000, 4'b0001);
        run_op("R3 imm max", 4'd3, 32'd0, 32'hFFFF_FFFF, 13'h0FFF, 1'b1, 1'b0, 32'h0000_0FFF, 4'b0001);
    endtask

    task automatic t_logic();
        logic [31:0] x = 32'h0000_3A0F;
        logic [31:0] y = 32'h0000_5555;
        run_op("R4 and",  4'd2, x, y, 13'd0, 1'b0, 1'b0, x & y, 4'b0001);
        run_op("R4 or",   4'd3, x, y, 13'd0, 1'b0, 1'b0, x | y, 4'b0001);
        run_op("R4 xor",  4'd4, x, y, 13'd0, 1'b0, 1'b0, x ^ y, 4'b0001);
        run_op("R4 andn", 4'd5, x, y, 13'd0, 1'b0, 1'b0, 32'h0000_2A0A, 4'b0001);
        run_op("R4 orn",  4'd6, x, y, 13'd0, 1'b0, 1'b0, 32'hFFFF_BAAF, 4'b0001);
        run_op("R4 xnor", 4'd7, x, y, 13'd0, 1'b0, 1'b0, 32'hFFFF_90A5, 4'b0001);
        // Set V first, then a bitwise write must clear V and C.
        run_op("R8 setup", 4'd0, 32'h7FFF_FFFF, 32'd1, 13'd0, 1'b0, 1'b1, 32'h8000_0000, 4'b1010);
        run_op("R10 xnor cc", 4'd7, x, y, 13'd0, 1'b0, 1'b1, 32'hFFFF_90A5, 4'b1000);
        run_op("R10 and zero cc", 4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 13'd0, 1'b0, 1'b1, 32'd0, 4'b0100);
    endtask

    task automatic t_shift();
        run_op("R5 sll", 4'd8, 32'd3, 32'h0000_0025, 13'd0, 1'b0, 1'b1, 32'd96, 4'b0100);
        run_op("R5 srl", 4'd9, 32'h8000_0000, 32'd31, 13'd0, 1'b0, 1'b1, 32'd1, 4'b0100);
        run_op("R5 sll zero count", 4'd8, 32'hABCD_0001, 32'h0000_0020, 13'd0, 1'b0, 1'b0, 32'hABCD_0001, 4'b0100);
        run_op("R6 sra", 4'd10, 32'h8000_0000, 32'd4, 13'd0, 1'b0, 1'b1, 32'hF800_0000, 4'b0100);
        run_op("R6 sra floor", 4'd10, 32'hFFFF_FFF9, 32'd0, 13'd1, 1'b1, 1'b0, 32'hFFFF_FFFC, 4'b0100);
        run_op("R6 sra positive", 4'd10, 32'h4000_0000, 32'd30, 13'd0, 1'b0, 1'b0, 32'd1, 4'b0100);
    endtask

    task automatic t_hold();
        run_op("R11 no cc add", 4'd0, 32'h7FFF_FFFF, 32'd1, 13'd0, 1'b0, 1'b0, 32'h8000_0000, 4'b0100);
        run_op("R11 no cc sub", 4'd1, 32'd1, 32'd2, 13'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'b0100);
    endtask

    task automatic t_unused();
        for (int k = 11; k < 16; k++)
            run_op("R12 unused op", 4'(k), 32'h1234_5678, 32'h9ABC_DEF0, 13'd0, 1'b0, 1'b1, 32'd0, 4'b0100);
        // Reset again after a nonzero flag value.
        t_reset();
    endtask

    initial begin
        rst_n = 1'b0; op_sel = '0; a = '0; b_reg = '0; imm13 = '0; use_imm = 1'b0; set_cc = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_imm();
        t_logic();
        t_shift();
        t_hold();
        t_unused();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule